// File: doc/BRIEF.md
# Control Endpoint Register Lock

This block keeps the mode register and the count/status register for each endpoint of a small USB function. Firmware and the serial interface engine both change these registers. When the engine finishes a transaction, it presents a one-cycle done strobe together with the packet type, the byte count, the data-valid flag, the toggle bit and a status-stage flag. The block then loads those results into the addressed endpoint and raises that endpoint's interrupt strobe.

Endpoint 0 is the control endpoint. After a SETUP or OUT result lands there, its two registers lock. Firmware writes to them are dropped until firmware reads either register. The read is the normal first step of the endpoint interrupt routine, and it releases the lock. No other endpoint ever locks.

A SETUP is taken in any mode. It forces mode 0001 and replaces any payload count that has not been consumed. An ACKed status OUT in mode 1111 (ACK IN, status OUT) drops the mode to 1110 (NAK IN, status OUT).

Top module: `ep_mode_lock_top`

## Requirements
- R1: After reset, every mode register and every count register reads 0 and every bit of irq_o is 0.
- R2: On an unlocked endpoint, a firmware write with sel=0 stores wdata[3:0] as the mode. A write with sel=1 stores wdata as the count register: bit 7 is the toggle, bit 6 is data valid and bits 5:0 are the byte count. Read data with sel=0 is the mode, zero-extended.
- R3: A SETUP (type 0) or OUT (type 1) result loads the count, valid and toggle fields. The new values are readable in the cycle after the done strobe.
- R4: After a SETUP or OUT result on endpoint 0, firmware writes to either endpoint 0 register have no effect while the lock is held.
- R5: A firmware read of either endpoint 0 register releases the lock. Writes issued after that read take effect.
- R6: Endpoints other than 0 never lock. A write in the cycle after an OUT result takes effect.
- R7: A SETUP result sets the mode to 0001 whatever the current mode is. It overwrites the count even when data valid is already set.
- R8: An OUT result with the status flag set, arriving in mode 1111, changes the mode to 1110. In any other mode, an OUT result leaves the mode unchanged.
- R9: When a firmware write and an engine result hit the same endpoint in the same cycle, the engine values are kept and the firmware write is dropped. On endpoint 0 the lock is set. A firmware read in that same cycle does not release the lock.
- R10: irq_o[e] is high for exactly the one cycle after each done strobe addressed to endpoint e.
- R11: An IN result (type 2) updates only the toggle bit. It leaves the count, valid and mode unchanged and does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fw_wr_i | input | 1 | Firmware write strobe |
| fw_rd_i | input | 1 | Firmware read strobe (releases the endpoint 0 lock) |
| fw_ep_i | input | EP_W | Endpoint addressed by firmware |
| fw_sel_i | input | 1 | Register select: 0 is mode, 1 is count/status |
| fw_wdata_i | input | CNT_W+2 | Firmware write data |
| fw_rdata_o | output | CNT_W+2 | Read data of the selected register |
| sie_done_i | input | 1 | Engine transaction-complete strobe |
| sie_ep_i | input | EP_W | Endpoint of the completed transaction |
| sie_pkt_i | input | 2 | Packet type: 0 SETUP, 1 OUT, 2 IN |
| sie_status_i | input | 1 | The transaction was a status stage |
| sie_tog_i | input | 1 | Resulting data toggle |
| sie_valid_i | input | 1 | Resulting data-valid flag |
| sie_cnt_i | input | CNT_W | Received byte count |
| irq_o | output | NUM_EP | Per-endpoint update strobe |

## Verification
Two events can meet in one cycle: a firmware write and an engine result, or a firmware read and an engine result, on the same endpoint. The bench drives both strobes in the same cycle. It then checks that the count holds the engine's values. It also checks that a later mode write is dropped, which shows the lock survived. A read that coincides with a result must likewise leave the following write ignored.

// File: rtl/ep_lock_pkg.sv
package ep_lock_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [1:0] {
    PKT_SETUP = 2'd0,
    PKT_OUT   = 2'd1,
    PKT_IN    = 2'd2,
    PKT_RSVD  = 2'd3
  } pkt_e;

  localparam logic [MODE_W-1:0] MODE_SETUP  = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_ACK_ST = 4'b1111;
  localparam logic [MODE_W-1:0] MODE_NAK_ST = 4'b1110;
endpackage

// File: rtl/ep_lock_slot.sv
module ep_lock_slot
  import ep_lock_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter bit LOCKABLE = 1'b0,
  localparam int REG_W   = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              upd_i,
  input  pkt_e              pkt_i,
  input  logic              status_i,
  input  logic              tog_i,
  input  logic              valid_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [REG_W-1:0]  cnt_reg_o,
  output logic              irq_o
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q, tog_q, lock_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      tog_q   <= 1'b0;
      lock_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= upd_i;
      if (upd_i) begin
        // engine result wins over any firmware access this cycle
        unique case (pkt_i)
          PKT_SETUP: begin
            mode_q  <= MODE_SETUP;
            cnt_q   <= cnt_i;
            valid_q <= valid_i;
            tog_q   <= tog_i;
            lock_q  <= LOCKABLE;
          end
          PKT_OUT: begin
            cnt_q   <= cnt_i;
            valid_q <= valid_i;
            tog_q   <= tog_i;
            lock_q  <= LOCKABLE;
            if (status_i && mode_q == MODE_ACK_ST) mode_q <= MODE_NAK_ST;
          end
          PKT_IN:  tog_q <= tog_i;
          default: ;
        endcase
      end else begin
        if (wr_i && !lock_q) begin
          if (sel_i) {tog_q, valid_q, cnt_q} <= wdata_i;
          else       mode_q <= wdata_i[MODE_W-1:0];
        end
        if (rd_i) lock_q <= 1'b0;
      end
    end
  end

  assign mode_o    = mode_q;
  assign cnt_reg_o = {tog_q, valid_q, cnt_q};
  assign irq_o     = irq_q;

  a_r4_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_i && !upd_i) |=> ($stable(mode_q) && $stable(cnt_q) && $stable(valid_q) && $stable(tog_q)));

  a_r5_read_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !upd_i) |=> !lock_q);

  a_r9_result_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (pkt_i == PKT_SETUP || pkt_i == PKT_OUT)) |=> (lock_q == LOCKABLE));

  a_r8_status_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && pkt_i == PKT_OUT && status_i && mode_q == MODE_ACK_ST) |=> (mode_q == MODE_NAK_ST));

  a_r7_setup_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && pkt_i == PKT_SETUP) |=> (mode_q == MODE_SETUP));

  a_r10_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> irq_q);

  a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> !irq_q);

  a_r11_in_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && pkt_i == PKT_IN) |=> ($stable(cnt_q) && $stable(mode_q) && $stable(valid_q)));
endmodule

// File: rtl/ep_lock_rdmux.sv
module ep_lock_rdmux
  import ep_lock_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2,
  parameter int REG_W  = 8
) (
  input  logic [NUM_EP-1:0][MODE_W-1:0] mode_i,
  input  logic [NUM_EP-1:0][REG_W-1:0]  cnt_i,
  input  logic [EP_W-1:0]               ep_i,
  input  logic                          sel_i,
  output logic [REG_W-1:0]              rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (ep_i == EP_W'(e)) rdata_o = sel_i ? cnt_i[e] : REG_W'(mode_i[e]);
    end
  end
endmodule

// File: rtl/ep_mode_lock_top.sv
module ep_mode_lock_top
  import ep_lock_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int CNT_W  = 6,
  parameter int EP_W   = $clog2(NUM_EP),
  localparam int REG_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fw_wr_i,
  input  logic              fw_rd_i,
  input  logic [EP_W-1:0]   fw_ep_i,
  input  logic              fw_sel_i,
  input  logic [REG_W-1:0]  fw_wdata_i,
  output logic [REG_W-1:0]  fw_rdata_o,
  input  logic              sie_done_i,
  input  logic [EP_W-1:0]   sie_ep_i,
  input  logic [1:0]        sie_pkt_i,
  input  logic              sie_status_i,
  input  logic              sie_tog_i,
  input  logic              sie_valid_i,
  input  logic [CNT_W-1:0]  sie_cnt_i,
  output logic [NUM_EP-1:0] irq_o
);
  logic [NUM_EP-1:0][MODE_W-1:0] mode_all;
  logic [NUM_EP-1:0][REG_W-1:0]  cnt_all;
  pkt_e                          pkt;

  assign pkt = pkt_e'(sie_pkt_i);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit_fw, hit_sie;
    assign hit_fw  = (fw_ep_i == EP_W'(e));
    assign hit_sie = sie_done_i && (sie_ep_i == EP_W'(e));

    ep_lock_slot #(
      .CNT_W   (CNT_W),
      .LOCKABLE(e == 0)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (fw_wr_i && hit_fw),
      .rd_i     (fw_rd_i && hit_fw),
      .sel_i    (fw_sel_i),
      .wdata_i  (fw_wdata_i),
      .upd_i    (hit_sie),
      .pkt_i    (pkt),
      .status_i (sie_status_i),
      .tog_i    (sie_tog_i),
      .valid_i  (sie_valid_i),
      .cnt_i    (sie_cnt_i),
      .mode_o   (mode_all[e]),
      .cnt_reg_o(cnt_all[e]),
      .irq_o    (irq_o[e])
    );
  end

  ep_lock_rdmux #(
    .NUM_EP(NUM_EP),
    .EP_W  (EP_W),
    .REG_W (REG_W)
  ) u_rdmux (
    .mode_i (mode_all),
    .cnt_i  (cnt_all),
    .ep_i   (fw_ep_i),
    .sel_i  (fw_sel_i),
    .rdata_o(fw_rdata_o)
  );

  a_r10_irq_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
endmodule

// File: tb/ep_mode_lock_tb.sv
module ep_mode_lock_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fw_wr = 0, fw_rd = 0, fw_sel = 0;
  logic [1:0] fw_ep = 0;
  logic [7:0] fw_wdata = 0;
  logic [7:0] fw_rdata;
  logic       sie_done = 0, sie_status = 0, sie_tog = 0, sie_valid = 0;
  logic [1:0] sie_ep = 0, sie_pkt = 0;
  logic [5:0] sie_cnt = 0;
  logic [3:0] irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ep_mode_lock_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fw_wr_i(fw_wr), .fw_rd_i(fw_rd), .fw_ep_i(fw_ep), .fw_sel_i(fw_sel),
    .fw_wdata_i(fw_wdata), .fw_rdata_o(fw_rdata),
    .sie_done_i(sie_done), .sie_ep_i(sie_ep), .sie_pkt_i(sie_pkt),
    .sie_status_i(sie_status), .sie_tog_i(sie_tog), .sie_valid_i(sie_valid),
    .sie_cnt_i(sie_cnt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic fw_write(input logic [1:0] ep, input logic sel, input logic [7:0] d);
    @(negedge clk);
    fw_wr = 1; fw_ep = ep; fw_sel = sel; fw_wdata = d;
    @(negedge clk);
    fw_wr = 0;
  endtask

  task automatic fw_read(input logic [1:0] ep, input logic sel, output logic [7:0] d);
    @(negedge clk);
    fw_rd = 1; fw_ep = ep; fw_sel = sel;
    #1 d = fw_rdata;
    @(negedge clk);
    fw_rd = 0;
  endtask

  task automatic peek(input logic [1:0] ep, input logic sel, output logic [7:0] d);
    @(negedge clk);
    fw_ep = ep; fw_sel = sel;
    #1 d = fw_rdata;
  endtask

  task automatic sie_set(input logic [1:0] ep, input logic [1:0] pkt, input logic st,
                         input logic tog, input logic vld, input logic [5:0] cnt);
    sie_done = 1; sie_ep = ep; sie_pkt = pkt; sie_status = st;
    sie_tog = tog; sie_valid = vld; sie_cnt = cnt;
  endtask

  task automatic sie_xact(input logic [1:0] ep, input logic [1:0] pkt, input logic st,
                          input logic tog, input logic vld, input logic [5:0] cnt,
                          output logic [3:0] irq_seen);
    @(negedge clk);
    sie_set(ep, pkt, st, tog, vld, cnt);
    @(negedge clk);
    sie_done = 0;
    irq_seen = irq;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", 32'(irq), 0);
    for (int e = 0; e < 4; e++) begin
      peek(2'(e), 0, d); chk("R1 mode", 32'(d), 0);
      peek(2'(e), 1, d); chk("R1 count", 32'(d), 0);
    end
  endtask

  task automatic t_fw_write();
    logic [7:0] d;
    fw_write(1, 0, 8'h05); fw_write(1, 1, 8'hC3);
    fw_read(1, 0, d); chk("R2 mode ep1", 32'(d), 5);
    fw_read(1, 1, d); chk("R2 count ep1", 32'(d), 8'hC3);
    fw_write(0, 0, 8'hFF);
    fw_read(0, 0, d); chk("R2 mode low nibble only", 32'(d), 8'h0F);
  endtask

  task automatic t_setup_lock();
    logic [7:0] d;
    logic [3:0] i;
    sie_xact(0, 0, 0, 0, 1, 6'd8, i);
    chk("R10 irq ep0", 32'(i), 4'b0001);
    @(negedge clk); chk("R10 irq one cycle", 32'(irq), 0);
    fw_write(0, 0, 8'h03); fw_write(0, 1, 8'h00);
    fw_read(0, 1, d); chk("R4 count kept while locked / R3 load", 32'(d), 8'h48);
    fw_read(0, 0, d); chk("R4 R7 mode kept at 0001", 32'(d), 1);
    fw_write(0, 0, 8'h03);
    fw_read(0, 0, d); chk("R5 write after read unlock", 32'(d), 3);
  endtask

  task automatic t_out_status();
    logic [7:0] d;
    logic [3:0] i;
    fw_write(0, 0, 8'h0F);
    sie_xact(0, 1, 1, 1, 1, 6'd0, i);
    fw_read(0, 0, d); chk("R8 1111 to 1110", 32'(d), 8'h0E);
    fw_read(0, 1, d); chk("R3 out result", 32'(d), 8'hC0);
    fw_write(0, 0, 8'h0B);
    sie_xact(0, 1, 1, 0, 0, 6'd0, i);
    fw_read(0, 0, d); chk("R8 other mode unchanged", 32'(d), 8'h0B);
  endtask

  task automatic t_setup_overwrite();
    logic [7:0] d;
    logic [3:0] i;
    fw_write(0, 0, 8'h0E); fw_write(0, 1, 8'h47);
    sie_xact(0, 0, 0, 0, 1, 6'd5, i);
    fw_read(0, 1, d); chk("R7 setup overwrites valid data", 32'(d), 8'h45);
    fw_read(0, 0, d); chk("R7 setup forces 0001 from NAK", 32'(d), 1);
  endtask

  task automatic t_ep1_nolock();
    logic [7:0] d;
    logic [3:0] i;
    sie_xact(1, 1, 0, 1, 1, 6'd2, i);
    chk("R10 irq ep1 only", 32'(i), 4'b0010);
    fw_write(1, 0, 8'h07);
    peek(1, 0, d); chk("R6 ep1 write not locked", 32'(d), 7);
  endtask

  task automatic t_in();
    logic [7:0] d;
    logic [3:0] i;
    fw_write(0, 1, 8'h09); fw_write(0, 0, 8'h02);
    sie_xact(0, 2, 0, 1, 0, 6'd33, i);
    fw_write(0, 0, 8'h06);
    peek(0, 0, d); chk("R11 no lock after IN", 32'(d), 6);
    peek(0, 1, d); chk("R11 only toggle changes", 32'(d), 8'h89);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk);
    fw_wr = 1; fw_ep = 0; fw_sel = 1; fw_wdata = 8'h00;
    sie_set(0, 1, 0, 0, 1, 6'd6);
    @(negedge clk);
    fw_wr = 0; sie_done = 0;
    peek(0, 1, d); chk("R9 engine wins write collision", 32'(d), 8'h46);
    fw_write(0, 0, 8'h0C);
    peek(0, 0, d); chk("R9 lock set on collision", 32'(d), 6);
    fw_read(0, 0, d);
    @(negedge clk);
    fw_rd = 1; fw_ep = 0; fw_sel = 0;
    sie_set(0, 1, 0, 1, 1, 6'd1);
    @(negedge clk);
    fw_rd = 0; sie_done = 0;
    fw_write(0, 0, 8'h0D);
    peek(0, 0, d); chk("R9 read with result keeps lock", 32'(d), 6);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fw_write();
        t_setup_lock();
        t_out_status();
        t_setup_overwrite();
        t_ep1_nolock();
        t_in();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule